// File: doc/BRIEF.md
# Multi-Mode Shift Register

A parameterised register, four bits wide by default, that performs one operation per rising clock edge. A three-bit mode code selects the operation. The register can keep its contents, take a parallel word, or move every bit one place. A move can be logical to the left or right, arithmetic to the left or right with the sign kept on a right move, or a rotate to the right. Each clock moves the contents by at most one position.

The two logical moves normally bring a zero into the vacated end. When the fill-enable input is high, they take the serial input bit instead. A second output holds the bit that left the register on the most recent move. A decode stage turns the mode code into a small set of strobes. A datapath stage holds the register and builds the next value bit by bit.

Top module: `mode_shift_reg`

## Requirements
- R1: When `rst` is high at a rising edge, `regOut` and `shiftOut` are both 0 after that edge, whatever the mode.
- R2: Mode codes 000 and 111 leave `regOut` and `shiftOut` unchanged.
- R3: Mode 001 copies `parIn` into `regOut` at the edge and leaves `shiftOut` unchanged.
- R4: Mode 010 (logical left) gives `regOut` = {old[W-2:0], fill} and `shiftOut` = old[W-1]. For example, 1101 becomes 1010 when the fill is 0.
- R5: Mode 011 (logical right) gives `regOut` = {fill, old[W-1:1]} and `shiftOut` = old[0]. For example, 1110 becomes 0111 when the fill is 0.
- R6: Mode 100 (arithmetic left) gives `regOut` = {old[W-2:0], 0} and `shiftOut` = old[W-1], whatever `fillEn` and `serialIn` are. For example, 1101 (-3) becomes 1010 (-6).
- R7: Mode 101 (arithmetic right) gives `regOut` = {old[W-1], old[W-1:1]} and `shiftOut` = old[0], whatever `fillEn` and `serialIn` are. For example, 1110 (-2) becomes 1111 (-1).
- R8: For modes 010 and 011, the fill bit is `serialIn` when `fillEn` is 1 and 0 when `fillEn` is 0. No other mode is affected by `serialIn` or `fillEn`.
- R9: Mode 110 (rotate right) gives `regOut` = {old[0], old[W-1:1]} and `shiftOut` = old[0]. For example, 0101 becomes 1010.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| mode | input | 3 | Operation code (see R2 to R9) |
| parIn | input | WIDTH | Parallel word for the load mode |
| fillEn | input | 1 | Use serialIn as the fill bit of the logical moves |
| serialIn | input | 1 | Serial fill bit |
| regOut | output | WIDTH | Register contents |
| shiftOut | output | 1 | Bit that left the register on the last move |

## Verification
The bench builds the block with WIDTH = 4, which makes a complete sweep small. Every starting value from 0 to 15 is loaded and then run through all eight mode codes, each with all four combinations of `fillEn` and `serialIn`. This covers sign propagation from negative values, the fill and serial inputs on every kind of move, and the state of `shiftOut` after loads and holds. A reset in the middle of the run, applied while `shiftOut` is 1, shows that the clear reaches both outputs.

// File: rtl/mshift_pkg.sv
package mshift_pkg;

  typedef enum logic [2:0] {
    OP_KEEP  = 3'b000,
    OP_LOAD  = 3'b001,
    OP_LSL   = 3'b010,
    OP_LSR   = 3'b011,
    OP_ASL   = 3'b100,
    OP_ASR   = 3'b101,
    OP_ROR   = 3'b110,
    OP_KEEP2 = 3'b111
  } opMode_e;

  // strobes from decode to datapath
  typedef struct packed {
    logic load;
    logic shiftLeft;
    logic shiftRight;
    logic keepSign;
    logic rotate;
    logic fillBit;
  } shStrobe_t;

endpackage

// File: rtl/mshift_ctrl.sv
module mshift_ctrl
  import mshift_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       fillEn,
  input  logic       serialIn,
  output shStrobe_t  strobe
);

  logic logicalFill;

  assign logicalFill = fillEn & serialIn;

  always_comb begin
    strobe = '0;
    case (opMode_e'(mode))
      OP_LOAD: strobe.load = 1'b1;
      OP_LSL: begin
        strobe.shiftLeft = 1'b1;
        strobe.fillBit   = logicalFill;
      end
      OP_LSR: begin
        strobe.shiftRight = 1'b1;
        strobe.fillBit    = logicalFill;
      end
      OP_ASL: strobe.shiftLeft = 1'b1;
      OP_ASR: begin
        strobe.shiftRight = 1'b1;
        strobe.keepSign   = 1'b1;
      end
      OP_ROR: begin
        strobe.shiftRight = 1'b1;
        strobe.rotate     = 1'b1;
      end
      default: strobe = '0;
    endcase
  end

endmodule

// File: rtl/mshift_dp.sv
module mshift_dp
  import mshift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  shStrobe_t        strobe,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] regQ,
  output logic             shiftOutQ
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] leftSrc;
  logic [WIDTH-1:0] rightSrc;
  logic [WIDTH-1:0] regNext;
  logic             outNext;
  logic             rightTop;

  always_comb begin
    if (strobe.rotate)        rightTop = regQ[0];
    else if (strobe.keepSign) rightTop = regQ[MSB];
    else                      rightTop = strobe.fillBit;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == 0) begin : g_lo
      assign leftSrc[i] = strobe.fillBit;
    end else begin : g_lmid
      assign leftSrc[i] = regQ[i-1];
    end
    if (i == MSB) begin : g_hi
      assign rightSrc[i] = rightTop;
    end else begin : g_rmid
      assign rightSrc[i] = regQ[i+1];
    end
  end

  always_comb begin
    regNext = regQ;
    outNext = shiftOutQ;
    if (strobe.load) begin
      regNext = parIn;
    end else if (strobe.shiftLeft) begin
      regNext = leftSrc;
      outNext = regQ[MSB];
    end else if (strobe.shiftRight) begin
      regNext = rightSrc;
      outNext = regQ[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regQ      <= '0;
      shiftOutQ <= 1'b0;
    end else begin
      regQ      <= regNext;
      shiftOutQ <= outNext;
    end
  end

  assert_one_op_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.load, strobe.shiftLeft, strobe.shiftRight}));

  assert_idle_stable_R2: assert property (@(posedge clk) disable iff (rst)
    !(strobe.load || strobe.shiftLeft || strobe.shiftRight)
      |=> ($stable(regQ) && $stable(shiftOutQ)));

  assert_load_capture_R3: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> (regQ == $past(parIn) && $stable(shiftOutQ)));

  assert_left_exit_R4: assert property (@(posedge clk) disable iff (rst)
    strobe.shiftLeft |=> (shiftOutQ == $past(regQ[MSB])));

  assert_right_exit_R5: assert property (@(posedge clk) disable iff (rst)
    strobe.shiftRight |=> (shiftOutQ == $past(regQ[0])));

  assert_sign_kept_R7: assert property (@(posedge clk) disable iff (rst)
    (strobe.shiftRight && strobe.keepSign) |=> (regQ[MSB] == $past(regQ[MSB])));

endmodule

// File: rtl/mode_shift_reg.sv
module mode_shift_reg
  import mshift_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic [WIDTH-1:0] parIn,
  input  logic             fillEn,
  input  logic             serialIn,
  output logic [WIDTH-1:0] regOut,
  output logic             shiftOut
);

  shStrobe_t strobe;

  mshift_ctrl i_ctrl (
    .mode     (mode),
    .fillEn   (fillEn),
    .serialIn (serialIn),
    .strobe   (strobe)
  );

  mshift_dp #(.WIDTH(WIDTH)) i_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .parIn     (parIn),
    .regQ      (regOut),
    .shiftOutQ (shiftOut)
  );

endmodule

// File: tb/test_mode_shift_reg.sv
module test_mode_shift_reg;

  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [2:0]   mode = 3'b000;
  logic [W-1:0] parIn = '0;
  logic         fillEn = 1'b0;
  logic         serialIn = 1'b0;
  logic [W-1:0] regOut;
  logic         shiftOut;

  int checks = 0;
  int errors = 0;
  int expReg = 0;
  int expOut = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  mode_shift_reg #(.WIDTH(W)) i_mode_shift_reg (
    .clk(clk), .rst(rst), .mode(mode), .parIn(parIn),
    .fillEn(fillEn), .serialIn(serialIn),
    .regOut(regOut), .shiftOut(shiftOut)
  );

  task automatic check(input string req);
    checks++;
    if (int'(regOut) != expReg || int'(shiftOut) != expOut) begin
      errors++;
      $display("FAIL %s: regOut=%0h shiftOut=%0d expected regOut=%0h shiftOut=%0d",
               req, regOut, shiftOut, expReg, expOut);
    end
  endtask

  // drive one cycle, update model from requirements, sample after edge
  task automatic apply(input int m, input int p, input int fe, input int si,
                       input bit doRst);
    string req;
    int fill, x;
    @(negedge clk);
    rst = doRst; mode = 3'(m); parIn = W'(p); fillEn = fe[0]; serialIn = si[0];
    x = expReg;
    fill = (fe != 0) ? si : 0;
    if (doRst) begin
      req = "R1"; expReg = 0; expOut = 0;
    end else begin
      case (m)
        1: begin req = "R3"; expReg = p & MASK; end
        2: begin req = (fe != 0) ? "R8" : "R4";
                 expReg = ((x << 1) & MASK) | fill; expOut = (x >> (W-1)) & 1; end
        3: begin req = (fe != 0) ? "R8" : "R5";
                 expReg = (x >> 1) | (fill << (W-1)); expOut = x & 1; end
        4: begin req = "R6"; expReg = (x << 1) & MASK; expOut = (x >> (W-1)) & 1; end
        5: begin req = "R7"; expReg = (x >> 1) | (x & (1 << (W-1))); expOut = x & 1; end
        6: begin req = "R9"; expReg = (x >> 1) | ((x & 1) << (W-1)); expOut = x & 1; end
        default: req = "R2";
      endcase
    end
    @(posedge clk);
    #1;
    check(req);
  endtask

  initial begin
    apply(1, 4'hF, 1, 1, 1'b1);   // R1 reset state
    apply(7, 4'h9, 1, 1, 1'b1);   // R1 again with other inputs
    for (int v = 0; v <= MASK; v++) begin
      for (int m = 0; m < 8; m++) begin
        for (int f = 0; f < 4; f++) begin
          apply(1, v, f >> 1, f & 1, 1'b0);        // load start value (R3)
          apply(m, ~v & MASK, f >> 1, f & 1, 1'b0); // operation under test
        end
      end
    end
    // R1: reset clears shiftOut after it was set
    apply(1, 4'b1011, 0, 0, 1'b0);
    apply(2, 0, 0, 0, 1'b0);
    apply(0, 0, 0, 0, 1'b1);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule